// File: doc/BRIEF.md
# Sleep-State Power Rail Sequencer

This block is a synchronous controller that brings five regulator rails up in a fixed order and takes them down again as the platform moves between its active, sleep and shutdown states. Two active-low inputs carry the platform state. A low sleep input with a high shutdown input requests sleep. A low shutdown input requests off. A third input reports that the main supply has passed its power-on-reset threshold. Each rail reports "in regulation" as a digital flag. The analog ramps are outside this block, and so is the fault detection, which arrives as a single latched-shutdown request.

After the main supply is good, the controller holds a reset phase of three soft-start windows. It then enables the rails stage by stage. Each stage waits one window and for its own rails to report good before the next stage starts. One window after the last rail, the power-good output may be released. In sleep, only the memory supply rail stays on, and the memory termination rail floats through a reference-short control. On the way back from sleep the same order runs again, with the memory supply left on. All pins are plain control and status levels; there is no streamed data and no handshake.

Top module: `rail_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the off state, `seq_state` is 0, `rail_en` is all zero, `pg_release` is 0 and `vtt_ref_short` is 1.
- R2: From off, with both sleep inputs high, the controller leaves off at the first edge where `main_por_ok` is high. It then holds status 1 with no rail enabled, other than the memory supply on a return from sleep, for exactly 3×`WIN_CYCLES` cycles.
- R3: The rail bits are `rail_en[0]` for the memory supply, `[1]` for the upper chipset, `[2]` for the lower chipset, `[3]` for the CPU/chipset termination and `[4]` for the memory termination. Status 2 enables bits 0–1, status 3 adds bit 2, status 4 adds bit 3 and status 5 adds bit 4. A rail is never on unless all rails of lower index are on.
- R4: Status 2, 3 and 4 each last at least `WIN_CYCLES` cycles. Each one advances at the first edge where its window is complete and its own rails' `rail_good` bits are high: bits 0 and 1, bit 2 or bit 3 in turn. Until then it stalls.
- R5: Status 5 lasts exactly `WIN_CYCLES` cycles and then becomes status 6, the active state, regardless of `rail_good`.
- R6: `pg_release` is a registered output. It is 1 after an edge only if the state after that edge is 6 and `rail_good[3]` was high at that edge.
- R7: `vtt_ref_short` is 1 exactly when `rail_en[4]` is 0.
- R8: `s3_sleep_n` low with `s5_off_n` high moves the block to status 7 at the next edge when the memory supply rail is already on. Status 7 has `rail_en` = 00001 and `pg_release` = 0. If the memory supply rail is not on, the block goes to off instead.
- R9: From status 7, the block enters the reset phase when `s3_sleep_n` is high and `main_por_ok` is high. It keeps `rail_en[0]` on through every later stage.
- R10: `s5_off_n` low forces off at the next edge from any state and also clears the return-from-sleep memory, so the next start is cold.
- R11: `latch_off` high forces off at the next edge. The block then stays off, whatever the other inputs do, until `s5_off_n` has been low and is high again.
- R12: The inputs take precedence in this order: `s5_off_n` low first, then the latched shutdown, then `s3_sleep_n` low. A low `s5_off_n` clears the latch even while `latch_off` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s3_sleep_n | input | 1 | Active-low sleep request |
| s5_off_n | input | 1 | Active-low shutdown request |
| main_por_ok | input | 1 | Main supply above its power-on-reset threshold |
| latch_off | input | 1 | Latched shutdown request from the fault block |
| rail_good | input | 5 | Per-rail in-regulation flags, same bit order as rail_en |
| rail_en | output | 5 | Per-rail enables |
| pg_release | output | 1 | 1 = power-good released to high impedance, 0 = driven low |
| vtt_ref_short | output | 1 | Shorts the memory termination reference to its output |
| seq_state | output | 3 | Current sequencer state code, 0–7 |

## Verification
The bench measures the length of the reset phase and of each stage to the cycle. A design that counts one window too few, or that advances a stage while its rail is still out of regulation, moves status early. The bench also checks a sleep request during a cold reset phase. A design that forgets the memory supply was never enabled would jump into the sleep state with that rail on. Finally, the bench applies a latched shutdown followed by further start requests, and shutdown together with sleep. A design with the wrong precedence, or one that clears the latch on a plain input toggle, would restart or sleep where it must stay off.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_RESET   = 3'd1,
    ST_STAGE_A = 3'd2,
    ST_STAGE_B = 3'd3,
    ST_STAGE_C = 3'd4,
    ST_STAGE_D = 3'd5,
    ST_ACTIVE  = 3'd6,
    ST_SLEEP   = 3'd7
  } seq_state_e;

  localparam int NUM_RAILS    = 5;
  localparam int RAIL_MEM     = 0;
  localparam int RAIL_CHIP_HI = 1;
  localparam int RAIL_CHIP_LO = 2;
  localparam int RAIL_CPU_TT  = 3;
  localparam int RAIL_MEM_TT  = 4;
  localparam int RESET_WINDOWS = 3;

endpackage

// File: rtl/rseq_timer.sv
module rseq_timer #(
  parameter int WIN_CYCLES = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic win_done,
  output logic rst_done
);
  import rseq_pkg::*;

  localparam int TOTAL = RESET_WINDOWS * WIN_CYCLES;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WIN_CYCLES - 1);
  localparam logic [CW-1:0] RST_LAST = CW'(TOTAL - 1);

  logic [CW-1:0] cnt_q;

  // One shared counter, saturating at the reset-phase length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr)             cnt_q <= '0;
    else if (cnt_q != RST_LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign win_done = (cnt_q >= WIN_LAST);
  assign rst_done = (cnt_q == RST_LAST);

endmodule

// File: rtl/rseq_fsm.sv
module rseq_fsm (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s3_n,
  input  logic                      s5_n,
  input  logic                      por_ok,
  input  logic                      latch_in,
  input  logic [rseq_pkg::NUM_RAILS-1:0] rail_good,
  input  logic                      win_done,
  input  logic                      rst_done,
  output rseq_pkg::seq_state_e      state_q,
  output rseq_pkg::seq_state_e      state_nxt,
  output logic                      warm_q,
  output logic                      tmr_clr
);
  import rseq_pkg::*;

  logic latched_q;
  logic mem_on;
  logic stage_ok;
  logic timed_state;

  always_comb begin
    mem_on = (state_q inside {ST_STAGE_A, ST_STAGE_B, ST_STAGE_C, ST_STAGE_D,
                              ST_ACTIVE, ST_SLEEP})
             || (state_q == ST_RESET && warm_q);

    unique case (state_q)
      ST_STAGE_A: stage_ok = rail_good[RAIL_MEM] & rail_good[RAIL_CHIP_HI];
      ST_STAGE_B: stage_ok = rail_good[RAIL_CHIP_LO];
      ST_STAGE_C: stage_ok = rail_good[RAIL_CPU_TT];
      default:    stage_ok = 1'b1;
    endcase

    state_nxt = state_q;
    if (!s5_n) begin
      state_nxt = ST_OFF;
    end else if (latch_in || latched_q) begin
      state_nxt = ST_OFF;
    end else if (!s3_n) begin
      state_nxt = mem_on ? ST_SLEEP : ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:     if (por_ok) state_nxt = ST_RESET;
        ST_RESET:   if (por_ok && rst_done) state_nxt = ST_STAGE_A;
        ST_STAGE_A: if (win_done && stage_ok) state_nxt = ST_STAGE_B;
        ST_STAGE_B: if (win_done && stage_ok) state_nxt = ST_STAGE_C;
        ST_STAGE_C: if (win_done && stage_ok) state_nxt = ST_STAGE_D;
        ST_STAGE_D: if (win_done) state_nxt = ST_ACTIVE;
        ST_ACTIVE:  state_nxt = ST_ACTIVE;
        ST_SLEEP:   if (por_ok) state_nxt = ST_RESET;
        default:    state_nxt = ST_OFF;
      endcase
    end

    timed_state = state_q inside {ST_RESET, ST_STAGE_A, ST_STAGE_B,
                                  ST_STAGE_C, ST_STAGE_D};
    tmr_clr = (state_nxt != state_q) || !timed_state
              || (state_q == ST_RESET && !por_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_OFF;
      warm_q    <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      state_q <= state_nxt;
      if (state_nxt == ST_SLEEP)    warm_q <= 1'b1;
      else if (state_nxt == ST_OFF) warm_q <= 1'b0;
      if (!s5_n)         latched_q <= 1'b0;
      else if (latch_in) latched_q <= 1'b1;
    end
  end

endmodule

// File: rtl/rseq_rail_map.sv
module rseq_rail_map (
  input  rseq_pkg::seq_state_e           state,
  input  logic                           warm,
  output logic [rseq_pkg::NUM_RAILS-1:0] rail_on,
  output logic                           ref_short
);
  import rseq_pkg::*;

  logic [2:0] code;
  assign code = state;

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
    // Rails up to the upper chipset share the first stage; each later rail owns one
    localparam logic [2:0] FIRST = (i <= RAIL_CHIP_HI) ? 3'(ST_STAGE_A) : 3'(i + 1);
    logic staged;
    assign staged = (code >= FIRST) && (code <= 3'(ST_ACTIVE));
    if (i == RAIL_MEM) begin : g_standby
      assign rail_on[i] = staged || (state == ST_SLEEP) || (state == ST_RESET && warm);
    end else begin : g_plain
      assign rail_on[i] = staged;
    end
  end

  assign ref_short = ~rail_on[RAIL_MEM_TT];

endmodule

// File: rtl/rseq_pg.sv
module rseq_pg (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rseq_pkg::seq_state_e state_nxt,
  input  logic                 cpu_tt_good,
  output logic                 pg_q
);
  import rseq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_q <= 1'b0;
    else        pg_q <= (state_nxt == ST_ACTIVE) && cpu_tt_good;
  end

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int WIN_CYCLES = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s3_sleep_n,
  input  logic       s5_off_n,
  input  logic       main_por_ok,
  input  logic       latch_off,
  input  logic [4:0] rail_good,
  output logic [4:0] rail_en,
  output logic       pg_release,
  output logic       vtt_ref_short,
  output logic [2:0] seq_state
);
  import rseq_pkg::*;

  seq_state_e st_q;
  seq_state_e st_nxt;
  logic       warm;
  logic       tmr_clr;
  logic       win_done;
  logic       rst_done;

  rseq_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .win_done (win_done),
    .rst_done (rst_done)
  );

  rseq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .s3_n      (s3_sleep_n),
    .s5_n      (s5_off_n),
    .por_ok    (main_por_ok),
    .latch_in  (latch_off),
    .rail_good (rail_good),
    .win_done  (win_done),
    .rst_done  (rst_done),
    .state_q   (st_q),
    .state_nxt (st_nxt),
    .warm_q    (warm),
    .tmr_clr   (tmr_clr)
  );

  rseq_rail_map u_map (
    .state     (st_q),
    .warm      (warm),
    .rail_on   (rail_en),
    .ref_short (vtt_ref_short)
  );

  rseq_pg u_pg (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_nxt   (st_nxt),
    .cpu_tt_good (rail_good[RAIL_CPU_TT]),
    .pg_q        (pg_release)
  );

  assign seq_state = st_q;

endmodule

// File: rtl/rail_sequencer_chk.sv
module rail_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s3_sleep_n,
  input logic       s5_off_n,
  input logic       latch_off,
  input logic [4:0] rail_en,
  input logic       pg_release,
  input logic [2:0] seq_state
);

  // R2
  reset_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd1) |-> (rail_en[4:1] == 4'b0000));

  // R3
  cascade_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en[4] |-> &rail_en[3:0]) and (rail_en[3] |-> &rail_en[2:0])
    and (rail_en[2] |-> &rail_en[1:0]) and (rail_en[1] |-> rail_en[0]));

  // R6
  pg_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_release |-> (seq_state == 3'd6 && rail_en == 5'b11111));

  // R8
  sleep_keeps_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s5_off_n && !latch_off && !s3_sleep_n && rail_en[0])
    |=> (rail_en == 5'b00001 && seq_state == 3'd7 && !pg_release));

  // R10
  shutdown_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s5_off_n |=> (rail_en == 5'b00000 && !pg_release && seq_state == 3'd0));

  // R11
  latch_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_off |=> (rail_en == 5'b00000 && seq_state == 3'd0));

endmodule

bind rail_sequencer rail_sequencer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s3_sleep_n (s3_sleep_n),
  .s5_off_n   (s5_off_n),
  .latch_off  (latch_off),
  .rail_en    (rail_en),
  .pg_release (pg_release),
  .seq_state  (seq_state)
);

// File: tb/rail_sequencer_tb_top.sv
module rail_sequencer_tb_top;

  localparam int WIN = 8;

  typedef struct packed {
    logic       s3;
    logic       s5;
    logic       por;
    logic       lat;
    logic [4:0] ok;
    logic [7:0] n;
    logic [2:0] st;
    logic [4:0] en;
    logic       pg;
    logic       sh;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,5'h1f,8'd3, 3'd0,5'h00,1'b0,1'b1,4'd2},  // R2 waits for POR
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd1,5'h00,1'b0,1'b1,4'd2},  // R2 enter reset
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd23,3'd1,5'h00,1'b0,1'b1,4'd2},  // R2 still reset
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd2,5'h03,1'b0,1'b1,4'd2},  // R2 exact length
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd7, 3'd2,5'h03,1'b0,1'b1,4'd4},  // R4 window
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd3,5'h07,1'b0,1'b1,4'd3},  // R3
    '{1'b1,1'b1,1'b1,1'b0,5'h1b,8'd20,3'd3,5'h07,1'b0,1'b1,4'd4},  // R4 stall
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd4,5'h0f,1'b0,1'b1,4'd4},  // R4 resume
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd7, 3'd4,5'h0f,1'b0,1'b1,4'd3},  // R3
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd5,5'h1f,1'b0,1'b0,4'd7},  // R7
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd7, 3'd5,5'h1f,1'b0,1'b0,4'd5},  // R5
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd6,5'h1f,1'b1,1'b0,4'd5},  // R5
    '{1'b1,1'b1,1'b1,1'b0,5'h17,8'd1, 3'd6,5'h1f,1'b0,1'b0,4'd6},  // R6 cpu tt low
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd6,5'h1f,1'b1,1'b0,4'd6},  // R6
    '{1'b0,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd7,5'h01,1'b0,1'b1,4'd8},  // R8 sleep
    '{1'b0,1'b1,1'b0,1'b0,5'h1f,8'd5, 3'd7,5'h01,1'b0,1'b1,4'd8},  // R8
    '{1'b1,1'b1,1'b0,1'b0,5'h1f,8'd3, 3'd7,5'h01,1'b0,1'b1,4'd9},  // R9 waits POR
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd1,5'h01,1'b0,1'b1,4'd9},  // R9 warm reset
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd24,3'd2,5'h03,1'b0,1'b1,4'd9},  // R9
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd8, 3'd3,5'h07,1'b0,1'b1,4'd9},  // R9
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd8, 3'd4,5'h0f,1'b0,1'b1,4'd9},  // R9
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd8, 3'd5,5'h1f,1'b0,1'b0,4'd9},  // R9
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd8, 3'd6,5'h1f,1'b1,1'b0,4'd9},  // R9
    '{1'b1,1'b0,1'b1,1'b0,5'h1f,8'd1, 3'd0,5'h00,1'b0,1'b1,4'd10}, // R10
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd1,5'h00,1'b0,1'b1,4'd10}, // R10 cold
    '{1'b1,1'b1,1'b1,1'b1,5'h1f,8'd1, 3'd0,5'h00,1'b0,1'b1,4'd11}, // R11
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd5, 3'd0,5'h00,1'b0,1'b1,4'd11}, // R11 held
    '{1'b1,1'b0,1'b1,1'b0,5'h1f,8'd1, 3'd0,5'h00,1'b0,1'b1,4'd11}, // R11
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd1,5'h00,1'b0,1'b1,4'd11}, // R11 cleared
    '{1'b0,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd0,5'h00,1'b0,1'b1,4'd8},  // R8 cold sleep
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd1,5'h00,1'b0,1'b1,4'd2},  // R2
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd24,3'd2,5'h03,1'b0,1'b1,4'd2},  // R2
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd8, 3'd3,5'h07,1'b0,1'b1,4'd3},  // R3
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd8, 3'd4,5'h0f,1'b0,1'b1,4'd3},  // R3
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd8, 3'd5,5'h1f,1'b0,1'b0,4'd3},  // R3
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd8, 3'd6,5'h1f,1'b1,1'b0,4'd5},  // R5
    '{1'b0,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd7,5'h01,1'b0,1'b1,4'd8},  // R8
    '{1'b0,1'b0,1'b1,1'b0,5'h1f,8'd1, 3'd0,5'h00,1'b0,1'b1,4'd12}, // R12 off beats sleep
    '{1'b0,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd0,5'h00,1'b0,1'b1,4'd12}, // R12
    '{1'b1,1'b1,1'b1,1'b1,5'h1f,8'd2, 3'd0,5'h00,1'b0,1'b1,4'd12}, // R12 latch beats start
    '{1'b1,1'b0,1'b1,1'b1,5'h1f,8'd1, 3'd0,5'h00,1'b0,1'b1,4'd12}, // R12
    '{1'b1,1'b1,1'b1,1'b0,5'h1f,8'd1, 3'd1,5'h00,1'b0,1'b1,4'd12}  // R12 latch cleared
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       s3_sleep_n, s5_off_n, main_por_ok, latch_off;
  logic [4:0] rail_good;
  logic [4:0] rail_en;
  logic       pg_release, vtt_ref_short;
  logic [2:0] seq_state;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rail_sequencer #(.WIN_CYCLES(WIN)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .s3_sleep_n    (s3_sleep_n),
    .s5_off_n      (s5_off_n),
    .main_por_ok   (main_por_ok),
    .latch_off     (latch_off),
    .rail_good     (rail_good),
    .rail_en       (rail_en),
    .pg_release    (pg_release),
    .vtt_ref_short (vtt_ref_short),
    .seq_state     (seq_state)
  );

  task automatic check(input int req, input int idx, input logic [2:0] st,
                       input logic [4:0] en, input logic pg, input logic sh);
    checks++;
    if (seq_state !== st || rail_en !== en || pg_release !== pg || vtt_ref_short !== sh) begin
      errors++;
      $display("FAIL R%0d step %0d: state=%0d en=%b pg=%b short=%b expected state=%0d en=%b pg=%b short=%b",
               req, idx, seq_state, rail_en, pg_release, vtt_ref_short, st, en, pg, sh);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; s3_sleep_n = 1'b1; s5_off_n = 1'b1; main_por_ok = 1'b1;
    latch_off = 1'b0; rail_good = 5'h1f;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state with every start condition present
    check(1, -1, 3'd0, 5'h00, 1'b0, 1'b1);
    main_por_ok = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      s3_sleep_n  = VEC[i].s3;
      s5_off_n    = VEC[i].s5;
      main_por_ok = VEC[i].por;
      latch_off   = VEC[i].lat;
      rail_good   = VEC[i].ok;
      repeat (int'(VEC[i].n)) @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i].req), i, VEC[i].st, VEC[i].en, VEC[i].pg, VEC[i].sh);
    end

    // R1: reset in the middle of stage A returns everything to off
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(2, 100, 3'd2, 5'h03, 1'b0, 1'b1);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(1, 101, 3'd0, 5'h00, 1'b0, 1'b1);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R2: cold restart after reset leaves memory supply off
    check(2, 102, 3'd1, 5'h00, 1'b0, 1'b1);

    // R4: upper chipset flag low stalls stage A past its window
    rail_good = 5'h1d;
    repeat (24 + 3 * WIN) @(posedge clk);
    @(negedge clk);
    check(4, 103, 3'd2, 5'h03, 1'b0, 1'b1);
    rail_good = 5'h1f;
    @(posedge clk);
    @(negedge clk);
    check(4, 104, 3'd3, 5'h07, 1'b0, 1'b1);

    // R5: stage D ignores rail_good
    repeat (2 * WIN) @(posedge clk);
    @(negedge clk);
    check(3, 105, 3'd5, 5'h1f, 1'b0, 1'b0);
    rail_good = 5'h00;
    repeat (WIN) @(posedge clk);
    @(negedge clk);
    // R6: active but cpu termination low keeps power-good driven
    check(5, 106, 3'd6, 5'h1f, 1'b0, 1'b0);

    finish_run();
  end

endmodule